// File: doc/BRIEF.md
# Signed-Digit Root to BCD Converter

This block sits behind a radix-10 digit-recurrence square-root datapath. The datapath hands over one signed root digit per accepted cycle, most significant digit first. The block builds the root in plain BCD while those digits arrive, so no carry-propagate pass is needed once the last digit is in. Two shifting digit registers do this work. One holds the root as received so far. The other holds that root minus one unit in its last place. Each incoming digit extends both registers, and a negative digit borrows by taking its digits from the minus-one register.

The stream carries one digit more than the requested precision. That extra guard digit, together with the sign and zero status of the final partial remainder, drives a round-to-nearest, ties-to-even step. The block registers the rounded BCD root and marks it with a one-cycle completion pulse. Cycles in which the valid strobe is low carry no digit and change nothing.

Top module: `sd_root_bcd_conv`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_done` goes to 0 and `res_bcd` goes to all zeros.
- R2: A stream is FRAC_DIGITS+2 digits, each accepted only on a cycle with `dig_valid` high. The first digit is the integer digit (0 or 1). The rest are fractional digits in -5..5, coded as 4-bit two's complement on `dig_val`. Digit values and remainder flags in cycles with `dig_valid` low have no effect on the result.
- R3: Streams made of positive and zero fractional digits convert to exactly the value of the signed-digit sum.
- R4: Streams with negative digits convert exactly. This includes a borrow that runs back through earlier digits and zeros that follow a negative digit.
- R5: `res_done` is high for exactly one cycle, the cycle after the guard digit (the last one) is accepted. `rem_neg` and `rem_zero` are sampled only together with that guard digit.
- R6: A guard digit above 5 rounds the kept digits up by one unit in the last place. A guard digit below 5 truncates.
- R7: A guard digit of exactly 5 with `rem_zero` high rounds to the even neighbour.
- R8: A guard digit of exactly 5 with a nonzero remainder rounds up.
- R9: With `rem_neg` high, the converted value is first reduced by one unit of the guard position, and the result is then rounded with the remainder treated as nonzero.
- R10: A round-up ripples through trailing 9 digits and can carry into the integer digit.
- R11: `res_bcd` puts the integer digit in bits [4*FRAC_DIGITS+3 : 4*FRAC_DIGITS], followed by the fractional digits with the most significant first, down to the least significant in bits [3:0]. Every nibble of `res_bcd` is in 0..9 when `res_done` is high.
- R12: `res_bcd` holds its value between completion pulses. A new stream may begin in the cycle right after a guard digit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dig_valid | input | 1 | A root digit is present on `dig_val` this cycle |
| dig_val | input | 4 | Signed root digit, two's complement |
| rem_neg | input | 1 | Final remainder is negative (sampled with the guard digit) |
| rem_zero | input | 1 | Final remainder is zero (sampled with the guard digit) |
| res_bcd | output | 4*(FRAC_DIGITS+1) | Rounded root: integer digit, then the fractional BCD digits |
| res_done | output | 1 | One-cycle pulse: `res_bcd` holds a new result |

## Verification
Two functions can fall in the same cycle. The first is the result pulse of one stream, together with the registers capturing the rounded value. The second is the integer digit of the next stream, which resets the conversion pair and the digit sequencer. The bench provokes this by sending streams back to back with no idle cycles. It judges each completion against a scoreboard entry that holds the exact value and the exact cycle the pulse is due. Separately, the guard-digit cycle itself combines the final conversion step with the negative-remainder selection and the rounding. The bench covers this with directed ties, a negative remainder that borrows through every digit, and a carry into the integer digit.

// File: rtl/sdrc_pkg.sv
// Shared types for the signed-digit root converter.
// Assumes radix-10 digits carried in 4-bit nibbles.
package sdrc_pkg;
    typedef logic signed [3:0] sdig_t;   // signed root digit, -5..5
    typedef logic        [3:0] bcd_t;    // one BCD digit, 0..9
    localparam bcd_t BCD_NINE = 4'd9;
endpackage

// File: rtl/sdrc_seq.sv
// Digit sequencer: counts the accepted digits of one stream and flags
// the integer digit (first) and the guard digit (last).
// Assumes NDIG >= 2 and that a stream is exactly NDIG valid digits.
module sdrc_seq #(
    parameter int NDIG = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic is_first,
    output logic is_last
);
    localparam int CW = $clog2(NDIG + 1);

    logic [CW-1:0] cnt;

    // advance on each accepted digit, wrap after the guard digit
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= is_last ? '0 : cnt + CW'(1);
    end

    assign is_first = (cnt == '0);
    assign is_last  = (cnt == CW'(NDIG - 1));
endmodule

// File: rtl/sdrc_otf_pair.sv
// On-the-fly conversion pair. It keeps the root so far (q) and the root
// minus one ulp (qm) as BCD digit strings, and appends one digit per step.
// The outputs give the strings including the digit being accepted, so the
// final value is available in the cycle of the last digit.
// Assumes the first digit is 0 or 1 and the later ones are in -5..5.
module sdrc_otf_pair
    import sdrc_pkg::*;
#(
    parameter int NDIG = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              first,
    input  sdig_t             dig,
    output logic [NDIG*4-1:0] q_nxt,
    output logic [NDIG*4-1:0] qm_nxt
);
    localparam int W  = NDIG * 4;
    localparam int RW = W - 4;          // stored digits before the last one

    logic [RW-1:0] q_r, qm_r;
    logic [RW-1:0] q_src, qm_src;
    bcd_t          q_dig, qm_dig;

    // choose which register each string continues from, and the appended digit
    always_comb begin
        if (first) begin
            q_src  = '0;
            qm_src = '0;
            q_dig  = bcd_t'(dig);
            qm_dig = (dig == 4'sd0) ? BCD_NINE : 4'd0;
        end else if (dig > 4'sd0) begin
            q_src  = q_r;
            qm_src = q_r;
            q_dig  = bcd_t'(dig);
            qm_dig = bcd_t'(dig) - 4'd1;
        end else if (dig == 4'sd0) begin
            q_src  = q_r;
            qm_src = qm_r;
            q_dig  = 4'd0;
            qm_dig = BCD_NINE;
        end else begin
            q_src  = qm_r;
            qm_src = qm_r;
            q_dig  = 4'd10 + bcd_t'(dig);
            qm_dig = 4'd9 + bcd_t'(dig);
        end
    end

    assign q_nxt  = {q_src, q_dig};
    assign qm_nxt = {qm_src, qm_dig};

    // shift the appended digit into both strings
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r  <= '0;
            qm_r <= '0;
        end else if (step) begin
            q_r  <= q_nxt[RW-1:0];
            qm_r <= qm_nxt[RW-1:0];
        end
    end
endmodule

// File: rtl/sdrc_round.sv
// Round-to-nearest-even of a BCD string. It drops the lowest (guard) digit
// and uses the remainder-zero flag as sticky information.
// Assumes every input nibble is 0..9. Purely combinational.
module sdrc_round
    import sdrc_pkg::*;
#(
    parameter int NDIG = 9
) (
    input  logic [NDIG*4-1:0]     val,
    input  logic                  rem_zero,
    output logic [(NDIG-1)*4-1:0] res
);
    localparam int KD = NDIG - 1;       // kept digits

    bcd_t           guard;
    logic [KD*4-1:0] kept;
    logic [KD-1:0]   cy;

    assign guard = val[3:0];
    assign kept  = val[NDIG*4-1:4];
    // round-up decision: above half, or half with sticky or odd last digit
    assign cy[0] = (guard > 4'd5) ||
                   ((guard == 4'd5) && (!rem_zero || kept[0]));

    for (genvar i = 0; i < KD; i++) begin : g_inc
        bcd_t d;
        assign d = kept[4*i +: 4];
        assign res[4*i +: 4] = (cy[i] && d == BCD_NINE) ? 4'd0 : d + {3'b000, cy[i]};
        if (i < KD - 1) begin : g_cy
            assign cy[i+1] = cy[i] && (d == BCD_NINE);
        end
    end
endmodule

// File: rtl/sd_root_bcd_conv.sv
// Top level: signed root digits in, rounded BCD root out. The guard digit
// cycle completes the conversion, selects root or root-minus-ulp by the
// remainder sign, rounds, and registers the result with a one-cycle pulse.
// Assumes FRAC_DIGITS >= 1 and well-formed digit streams.
module sd_root_bcd_conv
    import sdrc_pkg::*;
#(
    parameter int FRAC_DIGITS = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dig_valid,
    input  logic [3:0]                 dig_val,
    input  logic                       rem_neg,
    input  logic                       rem_zero,
    output logic [(FRAC_DIGITS+1)*4-1:0] res_bcd,
    output logic                       res_done
);
    localparam int NDIG = FRAC_DIGITS + 2;   // integer + fraction + guard
    localparam int W    = NDIG * 4;
    localparam int OW   = (FRAC_DIGITS + 1) * 4;

    logic          is_first, is_last;
    logic [W-1:0]  q_nxt, qm_nxt, sel_val;
    logic [OW-1:0] rnd;

    sdrc_seq #(.NDIG(NDIG)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (dig_valid),
        .is_first (is_first),
        .is_last  (is_last)
    );

    sdrc_otf_pair #(.NDIG(NDIG)) u_pair (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (dig_valid),
        .first  (is_first),
        .dig    (sdig_t'(dig_val)),
        .q_nxt  (q_nxt),
        .qm_nxt (qm_nxt)
    );

    // negative remainder: the true root lies just below the converted value
    assign sel_val = rem_neg ? qm_nxt : q_nxt;

    sdrc_round #(.NDIG(NDIG)) u_round (
        .val      (sel_val),
        .rem_zero (rem_zero),
        .res      (rnd)
    );

    // capture the rounded root on the guard digit and pulse completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_bcd  <= '0;
            res_done <= 1'b0;
        end else begin
            res_done <= dig_valid && is_last;
            if (dig_valid && is_last)
                res_bcd <= rnd;
        end
    end
endmodule

// File: rtl/sdrc_chk.sv
// Checker for the converter's port-level timing and output format.
// Attached to every instance of the top by the bind below.
module sdrc_chk #(
    parameter int FRAC_DIGITS = 7
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         dig_valid,
    input logic [(FRAC_DIGITS+1)*4-1:0] res_bcd,
    input logic                         res_done
);
    logic bcd_ok;

    // every output nibble is a legal decimal digit
    always_comb begin
        bcd_ok = 1'b1;
        for (int i = 0; i <= FRAC_DIGITS; i++)
            if (res_bcd[4*i +: 4] > 4'd9) bcd_ok = 1'b0;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_done && res_bcd == '0));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done);

    // R5
    done_after_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> $past(dig_valid));

    // R11
    legal_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |-> bcd_ok);

    // R12
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(res_bcd) |-> res_done);
endmodule

bind sd_root_bcd_conv sdrc_chk #(.FRAC_DIGITS(FRAC_DIGITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dig_valid (dig_valid),
    .res_bcd   (res_bcd),
    .res_done  (res_done)
);

// File: tb/sim_sd_root_bcd_conv.sv
module sim_sd_root_bcd_conv;
    localparam int FD = 7;
    localparam int ND = FD + 2;
    localparam int RW = (FD + 1) * 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dig_valid = 1'b0;
    logic [3:0]    dig_val = 4'd0;
    logic          rem_neg = 1'b0;
    logic          rem_zero = 1'b0;
    logic [RW-1:0] res_bcd;
    logic          res_done;

    sd_root_bcd_conv #(.FRAC_DIGITS(FD)) u0 (
        .clk(clk), .rst_n(rst_n), .dig_valid(dig_valid), .dig_val(dig_val),
        .rem_neg(rem_neg), .rem_zero(rem_zero), .res_bcd(res_bcd), .res_done(res_done)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct { longint v; int c; string tag; } exp_t;
    exp_t sb[$];
    int   digs[ND];

    // exact reference: signed-digit sum, remainder correction, ties to even
    function automatic longint ref_val(bit neg, bit zero);
        longint v = 0;
        longint t;
        longint g;
        bit     up;
        for (int j = 0; j < ND; j++) v = v * 10 + digs[j];
        if (neg) v = v - 1;
        g  = v % 10;
        t  = v / 10;
        up = (g > 5) || (g == 5 && (neg || !zero || (t % 2 == 1)));
        return t + (up ? 1 : 0);
    endfunction

    function automatic longint bcd2int(logic [RW-1:0] r, output bit bad);
        longint v = 0;
        bad = 1'b0;
        for (int i = FD; i >= 0; i--) begin
            if (r[4*i +: 4] > 4'd9) bad = 1'b1;
            v = v * 10 + longint'(r[4*i +: 4]);
        end
        return v;
    endfunction

    // driver: sends digs[] with optional idle gaps and pushes the expectation
    task automatic drive_stream(bit neg, bit zero, int gap_max, longint ev, string tag);
        for (int j = 0; j < ND; j++) begin
            int gaps = (gap_max > 0) ? int'($urandom_range(0, gap_max)) : 0;
            repeat (gaps) begin
                @(negedge clk);
                dig_valid = 1'b0;
                dig_val   = 4'($urandom);
                rem_neg   = 1'($urandom);
                rem_zero  = 1'($urandom);
            end
            @(negedge clk);
            dig_valid = 1'b1;
            dig_val   = 4'(digs[j]);
            if (j == ND - 1) begin
                rem_neg  = neg;
                rem_zero = zero;
                sb.push_back('{ev, cyc + 1, tag});
            end else begin
                rem_neg  = 1'($urandom);
                rem_zero = 1'($urandom);
            end
        end
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            dig_valid = 1'b0;
        end
    endtask

    task automatic rand_digs();
        digs[0] = int'($urandom_range(0, 1));
        digs[1] = (digs[0] == 1) ? -int'($urandom_range(0, 5)) : int'($urandom_range(1, 5));
        for (int j = 2; j < ND; j++) digs[j] = int'($urandom_range(0, 10)) - 5;
    endtask

    // monitor: pops the scoreboard on each completion, watches holding
    logic [RW-1:0] last_res = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_done) begin
                bit     bad;
                longint got;
                exp_t   e;
                n_chk++;
                got = bcd2int(res_bcd, bad);
                if (sb.size() == 0) begin
                    n_fail++;
                    $display("FAIL R5: unexpected completion, got %0d expected none", got);
                end else begin
                    e = sb.pop_front();
                    if (bad) begin
                        n_fail++;
                        $display("FAIL R11: non-BCD nibble, got %h expected digits 0..9", res_bcd);
                    end
                    if (got != e.v) begin
                        n_fail++;
                        $display("FAIL %s: got %0d expected %0d", e.tag, got, e.v);
                    end
                    if (cyc != e.c) begin
                        n_fail++;
                        $display("FAIL R5: completion at cycle %0d expected %0d", cyc, e.c);
                    end
                end
            end else if (res_bcd != last_res) begin
                n_fail++;
                $display("FAIL R12: result changed without completion, got %h expected %h",
                         res_bcd, last_res);
            end
            last_res = res_bcd;
        end
    end

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_chk++;
        if (res_done !== 1'b0 || res_bcd !== '0) begin
            n_fail++;
            $display("FAIL R1: got done=%b res=%h expected 0 and 0", res_done, res_bcd);
        end
        rst_n = 1'b1;
        idle(2);

        // R4: worked example, negative and positive remainder
        digs = '{1, -4, -1, 3, 5, -4, 3, 2, 3};
        drive_stream(1'b1, 1'b0, 0, 64'd5934632, "R4 example neg rem");
        drive_stream(1'b0, 1'b0, 0, 64'd5934632, "R4 example pos rem");
        // R2: same stream with idle gaps and junk on the idle cycles
        drive_stream(1'b1, 1'b0, 3, 64'd5934632, "R2 gaps ignored");
        idle(2);

        // R7: exact tie, even and odd last kept digit
        digs = '{0, 1, 0, 0, 0, 0, 0, 0, 5};
        drive_stream(1'b0, 1'b1, 0, 64'd1000000, "R7 tie even stays");
        // R8: tie with nonzero remainder
        drive_stream(1'b0, 1'b0, 0, 64'd1000001, "R8 tie sticky up");
        digs = '{0, 1, 0, 0, 0, 0, 0, 1, 5};
        drive_stream(1'b0, 1'b1, 0, 64'd1000002, "R7 tie odd up");

        // R9: negative remainder borrows through every digit, then rounds up
        digs = '{0, 1, 0, 0, 0, 0, 0, 0, 0};
        drive_stream(1'b1, 1'b0, 0, 64'd1000000, "R9 neg rem borrow");
        drive_stream(1'b0, 1'b1, 0, 64'd1000000, "R3 exact zero rem");

        // R6: guard above and below half
        digs = '{0, 3, 1, 4, 1, 5, 2, -3, -4};
        drive_stream(1'b0, 1'b0, 1, ref_val(1'b0, 1'b0), "R6 guard high");
        digs = '{0, 3, 1, 4, 1, 5, 2, 2, 4};
        drive_stream(1'b0, 1'b0, 1, 64'd3141522, "R6 guard low");

        // R10: carry into the integer digit
        digs = '{1, 0, 0, 0, 0, 0, 0, 0, -1};
        drive_stream(1'b0, 1'b0, 0, 64'd10000000, "R10 carry to integer");

        // R4: zeros after a negative digit
        digs = '{0, 5, -5, 0, 0, 0, 0, 0, 0};
        drive_stream(1'b0, 1'b1, 0, 64'd4500000, "R4 zeros after negative");
        idle(3);

        // R12: back-to-back streams, result pulse overlaps next integer digit
        for (int s = 0; s < 20; s++) begin
            bit nz = 1'($urandom);
            rand_digs();
            drive_stream(1'b0, nz, 0, ref_val(1'b0, nz), "R12 back-to-back");
        end
        idle(2);

        // R3: random streams with random remainder state and gaps
        for (int s = 0; s < 300; s++) begin
            int k = int'($urandom_range(0, 2));
            bit ng = (k == 1);
            bit zr = (k == 2);
            rand_digs();
            drive_stream(ng, zr, 2, ref_val(ng, zr), "R3 random stream");
        end
        idle(4);

        // R5: every expected completion must have appeared
        n_chk++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R5: got %0d pending results expected 0", sb.size());
        end
        finish_run();
    end
endmodule